// File: doc/BRIEF.md
# Reset and Start-up Timer Controller

This block combines every reason the processor core can be reset into a single system reset. Three sources feed it. The first is a power-on request, which comes from an analogue detector and arrives here as a digital input. The second is an external reset pin, which is active low. The third is a time-out from the watchdog, which counts only when the watchdog enable option is set. When every source has gone quiet, the block keeps the system in reset for a further start-up interval. This gives the oscillator time to settle. The interval is a parameterised number of clock cycles, sized at integration for roughly 18 ms of oscillator time.

While the system reset is active, the block overrides two values. It sends an all-zero program counter to the core in place of the value the core offers. It also forces every port direction bit to the input (high impedance) setting. The oscillator is kept running for the whole reset period, even if a sleep request tries to stop it. A small cause register records which source brought about the most recent reset, so that start-up code can tell them apart.

Any source that appears again during the hold period restarts the start-up count from zero. The release therefore always follows the last cause to go away by one full interval.

Top module: `rst_startup_ctl`

## Requirements
- R1: While `por` is high, `sys_rst` is high at once, without waiting for a clock edge, and `cause` reads 3'b001. After `por` falls, `sys_rst` falls on the HOLD_CYCLES-th rising clock edge.
- R2: A low level on `rst_pin_n` passes through SYNC_STAGES synchronising flops and then raises `sys_rst` on the next rising edge, which is edge SYNC_STAGES+1. After the pin returns high, `sys_rst` falls on edge SYNC_STAGES+HOLD_CYCLES.
- R3: When `wdt_en` is high, a one-cycle `wdt_timeout` pulse raises `sys_rst` on the edge that samples the pulse. `sys_rst` then falls HOLD_CYCLES edges after the pulse ends.
- R4: When `wdt_en` is low, `wdt_timeout` has no effect: `sys_rst` stays low and `cause` keeps its value.
- R5: If any source is seen again while `sys_rst` is held, the start-up count restarts. `sys_rst` stays high without a gap and falls one full interval after that source is removed.
- R6: While `sys_rst` is high, `pc_out` is all zeros and every bit of `dir_out` is 1, meaning input. While `sys_rst` is low, `pc_out` equals `pc_in` and `dir_out` equals `dir_in`.
- R7: `cause` is one-hot: bit 0 means power-on, bit 1 means pin, bit 2 means watchdog. If the pin and an enabled watchdog are both seen on the same edge, the pin is recorded. The value is kept until the next reset.
- R8: `osc_run` is high whenever `sys_rst` is high. Otherwise it equals the inverse of `osc_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Power-on request, active high, asynchronous assert |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| wdt_en | input | 1 | Watchdog enable option; when low, time-outs are ignored |
| osc_stop | input | 1 | Sleep request to stop the oscillator |
| pc_in | input | PC_W | Program counter offered by the core |
| dir_in | input | NUM_PORTS*PORT_W | Port direction bits offered by the core (1 = input) |
| sys_rst | output | 1 | Merged and stretched system reset |
| osc_run | output | 1 | Oscillator enable |
| pc_out | output | PC_W | Program counter after the reset override |
| dir_out | output | NUM_PORTS*PORT_W | Direction bits after the reset override |
| cause | output | 3 | One-hot cause of the most recent reset |

## Verification
The bench counts the exact number of edges from the release of each source to the fall of `sys_rst`. A stretch that is one cycle short or long, or a synchroniser that drops or adds a stage, therefore shows up as a wrong count. The bench sweeps a reassertion across every position inside the hold window. A counter that fails to restart would release the system early, and a restart that clears the hold flag would show a one-cycle gap in reset. It also pulses the watchdog while the enable option is off, where a missing gate would start a reset or overwrite `cause`. Finally, it fires the pin and the watchdog together, where the wrong priority would leave watchdog in the cause register.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;

   localparam int CAUSE_W = 3;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_POR = 3'b001,
      CAUSE_PIN = 3'b010,
      CAUSE_WDT = 3'b100
   } rst_cause_e;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por,
   input  logic d,
   output logic q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("rst_pin_sync: STAGES must lie in 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else if (STAGES == 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or posedge por) begin
         if (por) s_q <= 1'b0;
         else     s_q <= d;
      end
      assign q = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or posedge por) begin
         if (por) sh_q <= '0;
         else     sh_q <= {sh_q[STAGES-2:0], d};
      end
      assign q = sh_q[STAGES-1];
   end

endmodule

// File: rtl/rst_src_merge.sv
module rst_src_merge
   import rst_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       por,
   input  logic       pin_low,
   input  logic       wdt_timeout,
   input  logic       wdt_en,
   output logic       src_act,
   output rst_cause_e cause
);

   logic wdt_hit;

   assign wdt_hit = wdt_timeout & wdt_en;
   assign src_act = pin_low | wdt_hit;

   // The pin takes priority when both sources are seen on the same edge.
   always_ff @(posedge clk or posedge por) begin
      if (por)          cause <= CAUSE_POR;
      else if (pin_low) cause <= CAUSE_PIN;
      else if (wdt_hit) cause <= CAUSE_WDT;
   end

   AST_WDT_MASKED: assert property (@(posedge clk) disable iff (por)
      (!wdt_en && !pin_low) |=> $stable(cause)); // R4

   AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (por)
      $onehot(cause)); // R7

   AST_PIN_WINS: assert property (@(posedge clk) disable iff (por)
      pin_low |=> (cause == CAUSE_PIN)); // R7

endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
   parameter int HOLD_CYCLES = 72000
) (
   input  logic clk,
   input  logic por,
   input  logic src_act,
   output logic hold
);

   localparam int CNT_W = $clog2(HOLD_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("rst_hold_timer: HOLD_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         hold  <= 1'b1;
         cnt_q <= '0;
      end else if (src_act) begin
         hold  <= 1'b1;
         cnt_q <= '0;
      end else if (hold) begin
         if (cnt_q == LAST) begin
            hold  <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_SRC_RESTART: assert property (@(posedge clk) disable iff (por)
      src_act |=> (hold && cnt_q == '0)); // R5

   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (por)
      (hold && !src_act && cnt_q != LAST) |=> hold); // R5

   AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (por)
      (hold && !src_act && cnt_q == LAST) |=> !hold); // R1

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (por)
      cnt_q <= LAST); // R5

endmodule

// File: rtl/rst_force_mux.sv
module rst_force_mux #(
   parameter int   PC_W         = 10,
   parameter int   PORT_W       = 8,
   parameter int   NUM_PORTS    = 2,
   parameter logic DIR_IN_LEVEL = 1'b1
) (
   input  logic                        force_en,
   input  logic [PC_W-1:0]             pc_in,
   input  logic [NUM_PORTS*PORT_W-1:0] dir_in,
   output logic [PC_W-1:0]             pc_out,
   output logic [NUM_PORTS*PORT_W-1:0] dir_out
);

   if (PC_W < 1 || PORT_W < 1 || NUM_PORTS < 1) begin : g_bad_width
      $error("rst_force_mux: widths and port count must be positive");
   end

   assign pc_out = force_en ? '0 : pc_in;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign dir_out[p*PORT_W +: PORT_W] =
         force_en ? {PORT_W{DIR_IN_LEVEL}} : dir_in[p*PORT_W +: PORT_W];
   end

endmodule

// File: rtl/rst_startup_ctl.sv
module rst_startup_ctl
   import rst_ctl_pkg::*;
#(
   parameter int HOLD_CYCLES = 72000,
   parameter int SYNC_STAGES = 2,
   parameter int PC_W        = 10,
   parameter int PORT_W      = 8,
   parameter int NUM_PORTS   = 2
) (
   input  logic                        clk,
   input  logic                        por,
   input  logic                        rst_pin_n,
   input  logic                        wdt_timeout,
   input  logic                        wdt_en,
   input  logic                        osc_stop,
   input  logic [PC_W-1:0]             pc_in,
   input  logic [NUM_PORTS*PORT_W-1:0] dir_in,
   output logic                        sys_rst,
   output logic                        osc_run,
   output logic [PC_W-1:0]             pc_out,
   output logic [NUM_PORTS*PORT_W-1:0] dir_out,
   output logic [CAUSE_W-1:0]          cause
);

   logic       pin_low;
   logic       src_act;
   rst_cause_e cause_e;

   rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .por (por),
      .d   (~rst_pin_n),
      .q   (pin_low)
   );

   rst_src_merge u_merge (
      .clk         (clk),
      .por         (por),
      .pin_low     (pin_low),
      .wdt_timeout (wdt_timeout),
      .wdt_en      (wdt_en),
      .src_act     (src_act),
      .cause       (cause_e)
   );

   rst_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk     (clk),
      .por     (por),
      .src_act (src_act),
      .hold    (sys_rst)
   );

   rst_force_mux #(
      .PC_W         (PC_W),
      .PORT_W       (PORT_W),
      .NUM_PORTS    (NUM_PORTS),
      .DIR_IN_LEVEL (1'b1)
   ) u_force (
      .force_en (sys_rst),
      .pc_in    (pc_in),
      .dir_in   (dir_in),
      .pc_out   (pc_out),
      .dir_out  (dir_out)
   );

   assign cause   = cause_e;
   assign osc_run = sys_rst | ~osc_stop;

   AST_PC_FORCED: assert property (@(posedge clk) disable iff (por)
      sys_rst |-> (pc_out == '0)); // R6

   AST_DIR_FORCED: assert property (@(posedge clk) disable iff (por)
      sys_rst |-> (&dir_out)); // R6

   AST_OSC_ON: assert property (@(posedge clk) disable iff (por)
      sys_rst |-> osc_run); // R8

   AST_WDT_RESETS: assert property (@(posedge clk) disable iff (por)
      (wdt_timeout && wdt_en) |=> sys_rst); // R3

endmodule

// File: tb/tb_rst_startup_ctl.sv
module tb_rst_startup_ctl;

   localparam int HOLD  = 6;
   localparam int SYNC  = 2;
   localparam int PCW   = 4;
   localparam int PW    = 4;
   localparam int NP    = 2;
   localparam int DW    = NP * PW;

   logic          clk = 1'b0;
   logic          por = 1'b0;
   logic          rst_pin_n = 1'b1;
   logic          wdt_timeout = 1'b0;
   logic          wdt_en = 1'b0;
   logic          osc_stop = 1'b1;
   logic [PCW-1:0] pc_in = 4'hA;
   logic [DW-1:0]  dir_in = 8'h35;
   logic          sys_rst;
   logic          osc_run;
   logic [PCW-1:0] pc_out;
   logic [DW-1:0]  dir_out;
   logic [2:0]     cause;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   rst_startup_ctl #(
      .HOLD_CYCLES (HOLD),
      .SYNC_STAGES (SYNC),
      .PC_W        (PCW),
      .PORT_W      (PW),
      .NUM_PORTS   (NP)
   ) dut (
      .clk         (clk),
      .por         (por),
      .rst_pin_n   (rst_pin_n),
      .wdt_timeout (wdt_timeout),
      .wdt_en      (wdt_en),
      .osc_stop    (osc_stop),
      .pc_in       (pc_in),
      .dir_in      (dir_in),
      .sys_rst     (sys_rst),
      .osc_run     (osc_run),
      .pc_out      (pc_out),
      .dir_out     (dir_out),
      .cause       (cause)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Counts falling edges, starting after a source is removed, until sys_rst is low.
   task automatic measure(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (sys_rst && n < 200);
   endtask

   task automatic wdt_pulse();
      @(negedge clk);
      wdt_timeout = 1'b1;
      @(negedge clk);
      wdt_timeout = 1'b0;
   endtask

   initial begin
      #200000;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int n;
      #1 por = 1'b1;
      #1;
      chk("R1", "sys_rst on power-on", int'(sys_rst), 1);
      chk("R1", "cause on power-on", int'(cause), 1);
      chk("R8", "osc_run in reset with stop", int'(osc_run), 1);

      // R6: override sweep while reset is active
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         pc_in  = PCW'(v);
         dir_in = {4'(~v), 4'(v)};
         #1;
         chk("R6", "pc_out forced", int'(pc_out), 0);
         chk("R6", "dir_out forced", int'(dir_out), 255);
      end

      @(negedge clk);
      por = 1'b0;
      measure(n);
      chk("R1", "release after power-on", n, HOLD);
      chk("R7", "cause kept power-on", int'(cause), 1);

      // R6 and R8: pass-through sweep out of reset
      for (int v = 0; v < 16; v++) begin
         pc_in    = PCW'(v);
         dir_in   = {4'(v), 4'(15 - v)};
         osc_stop = v[0];
         #1;
         chk("R6", "pc_out pass", int'(pc_out), v);
         chk("R6", "dir_out pass", int'(dir_out), v * 16 + (15 - v));
         chk("R8", "osc_run follows stop", int'(osc_run), 1 - (v % 2));
         @(negedge clk);
      end

      // R2: pin latency and release
      rst_pin_n = 1'b0;
      repeat (SYNC) @(negedge clk);
      chk("R2", "no reset before sync", int'(sys_rst), 0);
      @(negedge clk);
      chk("R2", "reset after sync", int'(sys_rst), 1);
      repeat (3) @(negedge clk);
      chk("R7", "cause pin", int'(cause), 2);
      rst_pin_n = 1'b1;
      measure(n);
      chk("R2", "release after pin", n, SYNC + HOLD);

      // R4: watchdog ignored while disabled
      wdt_en = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         wdt_timeout = 1'b1;
         @(negedge clk);
         chk("R4", "no reset when disabled", int'(sys_rst), 0);
         chk("R4", "cause unchanged", int'(cause), 2);
      end
      wdt_timeout = 1'b0;

      // R3: enabled watchdog
      wdt_en = 1'b1;
      @(negedge clk);
      wdt_timeout = 1'b1;
      @(negedge clk);
      wdt_timeout = 1'b0;
      chk("R3", "reset on time-out", int'(sys_rst), 1);
      measure(n);
      chk("R3", "release after watchdog", n, HOLD);
      chk("R7", "cause watchdog", int'(cause), 4);

      // R5: restart at every position in the hold window, watchdog source
      for (int k = 0; k < HOLD - 1; k++) begin
         int gaps;
         wdt_pulse();
         gaps = 0;
         for (int j = 0; j < k; j++) begin
            @(negedge clk);
            if (!sys_rst) gaps++;
         end
         wdt_timeout = 1'b1;
         @(negedge clk);
         wdt_timeout = 1'b0;
         if (!sys_rst) gaps++;
         chk("R5", "no gap on restart", gaps, 0);
         measure(n);
         chk("R5", "full interval after restart", n, HOLD);
      end

      // R5: pin reasserted during hold
      for (int k = 0; k < HOLD - 1; k++) begin
         wdt_pulse();
         repeat (k) @(negedge clk);
         rst_pin_n = 1'b0;
         repeat (SYNC + 1) @(negedge clk);
         rst_pin_n = 1'b1;
         measure(n);
         chk("R5", "pin restart interval", n, SYNC + HOLD);
      end

      // R7: pin and watchdog together
      @(negedge clk);
      rst_pin_n   = 1'b0;
      wdt_timeout = 1'b1;
      repeat (SYNC + 2) @(negedge clk);
      wdt_timeout = 1'b0;
      rst_pin_n   = 1'b1;
      #1;
      chk("R7", "pin wins over watchdog", int'(cause), 2);
      measure(n);
      chk("R7", "cause held after release", int'(cause), 2);

      // R1: new power-on is asynchronous
      #2;
      por = 1'b1;
      #1;
      chk("R1", "async assert", int'(sys_rst), 1);
      chk("R1", "cause back to power-on", int'(cause), 1);
      @(negedge clk);
      por = 1'b0;
      measure(n);
      chk("R1", "second power-on release", n, HOLD);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule